// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down-counters that advance on a shared count-enable strobe, taken from a fixed timing source (nominally 1193182 Hz). Software reaches it through a byte-wide register port. One command address selects a channel and either programs its operating mode or freezes a snapshot of its count. Each channel has its own data address, through which a reload value is written as two bytes and a count is read back as two bytes.

Channel 0 usually runs as a rate generator, and each full count raises an interrupt request that software acknowledges through a system control register. Channel 2 usually runs as a square-wave generator, and its output reaches the speaker pin only when a gate bit in that same register is set. To get a periodic rate f, software loads the reload value round(1193182 / f). A reload of zero gives the longest period.

Top module: `pit_timer`

## Requirements
- R1: After reset, irq_o and spk_o are 0, every bit of tmr_out is 1, and a read of the system control address returns 0x20.
- R2: Address map: addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2, address 3 is the command port, and address 4 is the system control register. In a command byte, bits [7:6] pick the channel, and the value 3 selects no channel. Bits [5:4] equal to 00 make the byte a latch command. Any other value programs the mode from bits [3:1]: 3 selects square wave and every other value selects rate generator. Programming a mode stops that channel until a full count has been loaded.
- R3: A count load is a low-byte write followed by a high-byte write to the channel's data port. The new value starts counting only on the high byte. After only the low byte, the old count keeps running.
- R4: In rate-generator mode with reload N, a channel is reloaded every N ticks. Its output is 0 while the count equals 1 and is 1 otherwise.
- R5: A reload value of 0x0000 gives a period of 65536 ticks.
- R6: A latch command captures the channel's count. The next two data-port reads return the captured low byte and then the captured high byte, while counting continues.
- R7: While a snapshot is held, further latch commands to that channel are ignored until both of its bytes have been read.
- R8: In square-wave mode with reload N, the output is 1 for ceil(N/2) ticks and 0 for floor(N/2) ticks of each period.
- R9: spk_o is 1 only when channel 2's output is 1 and the gate bit (bit 0 of the system control register) is set.
- R10: Each reload of channel 0 sets irq_o. Writing the system control register with bit 7 set clears it, and a write with bit 7 clear leaves it set. If a reload and a clear fall in the same cycle, the reload wins.
- R11: A read of the system control address returns irq_o in bit 7, channel 2's output in bit 5, the gate bit in bit 0, and 0 in the other bits.
- R12: Counters change only on cycles where cnt_tick is 1 or a count load completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Count-enable strobe, one tick per cycle it is high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe, advances the byte pointer |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq_o | output | 1 | Channel 0 interrupt request |
| spk_o | output | 1 | Gated channel 2 tone |
| tmr_out | output | 3 | Output level of each channel |

## Verification
Writes, latch commands and reload events take effect on the clock edge that ends the bus or tick cycle. irq_o, tmr_out and spk_o therefore change right after that edge, and the bench samples them at the following falling edge. Read data is combinational, so the bench captures bus_rdata in the same low phase in which it raises bus_rd, and the byte pointer moves at the next edge. Periods are measured by holding cnt_tick high and counting falling edges until irq_o is seen. Each tick is thus counted in the same cycle the reload occurs.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int CNT_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] ADDR_CMD = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_SYS = 3'd4;

    localparam int SYS_IRQ_BIT  = 7;
    localparam int SYS_TONE_BIT = 5;
    localparam int SYS_GATE_BIT = 0;

    typedef enum logic {
        MODE_RATE   = 1'b0,
        MODE_SQUARE = 1'b1
    } ch_mode_e;

    typedef struct packed {
        ch_mode_e mode;
        logic     running;
        logic     wr_hi;
        logic     rd_hi;
        logic     held;
    } ch_state_t;

    // zero stands for the full 2^CNT_W range
    function automatic logic [CNT_W:0] eff_count(input logic [CNT_W-1:0] v);
        return (v == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, v};
    endfunction

    function automatic ch_mode_e mode_of(input logic [2:0] m);
        return (m == 3'd3) ? MODE_SQUARE : MODE_RATE;
    endfunction

endpackage

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              cfg_wr,
    input  ch_mode_e          cfg_mode,
    input  logic              latch_cmd,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              out,
    output logic              evt,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  rld,
    output logic              held,
    output logic [CNT_W-1:0]  snap
);

    logic [CNT_W-1:0]  count_q, reload_q, snap_q, count_n, src;
    logic [BYTE_W-1:0] lo_buf_q;
    ch_state_t         st_q;
    logic              load_done, advance;
    logic [CNT_W:0]    ceff, reff;

    assign load_done = data_wr && st_q.wr_hi && !cfg_wr;
    assign advance   = tick && st_q.running && !cfg_wr && !load_done;
    assign evt       = advance && (count_q == CNT_W'(1));

    always_comb begin
        count_n = count_q;
        if (load_done)
            count_n = {wdata, lo_buf_q};
        else if (advance)
            count_n = (count_q == CNT_W'(1)) ? reload_q : count_q - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            reload_q <= '0;
            snap_q   <= '0;
            lo_buf_q <= '0;
            st_q     <= '0;
        end else begin
            count_q <= count_n;
            if (cfg_wr) begin
                st_q.mode    <= cfg_mode;
                st_q.running <= 1'b0;
                st_q.wr_hi   <= 1'b0;
                st_q.rd_hi   <= 1'b0;
                st_q.held    <= 1'b0;
            end else begin
                if (data_wr) begin
                    if (!st_q.wr_hi) begin
                        lo_buf_q   <= wdata;
                        st_q.wr_hi <= 1'b1;
                    end else begin
                        reload_q     <= {wdata, lo_buf_q};
                        st_q.running <= 1'b1;
                        st_q.wr_hi   <= 1'b0;
                    end
                end
                if (latch_cmd && !st_q.held) begin
                    snap_q     <= count_q;
                    st_q.held  <= 1'b1;
                    st_q.rd_hi <= 1'b0;
                end else if (data_rd) begin
                    if (st_q.rd_hi) begin
                        st_q.rd_hi <= 1'b0;
                        st_q.held  <= 1'b0;
                    end else begin
                        st_q.rd_hi <= 1'b1;
                    end
                end
            end
        end
    end

    assign src   = st_q.held ? snap_q : count_q;
    assign rdata = st_q.rd_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];

    assign ceff = eff_count(count_q);
    assign reff = eff_count(reload_q);

    always_comb begin
        if (!st_q.running)
            out = 1'b1;
        else if (st_q.mode == MODE_SQUARE)
            out = (ceff > (reff >> 1));
        else
            out = (count_q != CNT_W'(1));
    end

    assign cnt  = count_q;
    assign rld  = reload_q;
    assign held = st_q.held;
    assign snap = snap_q;

endmodule

// File: rtl/pit_sysctl.sv
module pit_sysctl
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              gate_in,
    input  logic              clr_in,
    input  logic              set_evt,
    input  logic              tone,
    output logic              gate_o,
    output logic              irq_o,
    output logic [BYTE_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_o <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            if (wr)
                gate_o <= gate_in;
            if (set_evt)
                irq_o <= 1'b1;
            else if (wr && clr_in)
                irq_o <= 1'b0;
        end
    end

    always_comb begin
        rdata               = '0;
        rdata[SYS_IRQ_BIT]  = irq_o;
        rdata[SYS_TONE_BIT] = tone;
        rdata[SYS_GATE_BIT] = gate_o;
    end

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int IRQ_CH = 0,
    parameter int SPK_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              spk_o,
    output logic [NUM_CH-1:0] tmr_out
);

    localparam int SEL_W = 2;

    logic                          cmd_wr, sys_wr, sys_gate;
    logic [SEL_W-1:0]              cmd_sel;
    logic                          cmd_is_latch;
    ch_mode_e                      cmd_mode;
    logic [BYTE_W-1:0]             sys_rdata;
    logic [NUM_CH-1:0]             ch_evt, ch_held;
    logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt, ch_rld, ch_snap;
    logic [NUM_CH-1:0][BYTE_W-1:0] ch_rdata;

    assign cmd_wr       = bus_wr && (bus_addr == ADDR_CMD);
    assign sys_wr       = bus_wr && (bus_addr == ADDR_SYS);
    assign cmd_sel      = bus_wdata[7:6];
    assign cmd_is_latch = (bus_wdata[5:4] == 2'b00);
    assign cmd_mode     = mode_of(bus_wdata[3:1]);

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        logic hit;
        assign hit = cmd_wr && (cmd_sel == SEL_W'(gi));

        pit_channel u_ch (
            .clk       (clk),
            .rst       (rst),
            .tick      (cnt_tick),
            .cfg_wr    (hit && !cmd_is_latch),
            .cfg_mode  (cmd_mode),
            .latch_cmd (hit && cmd_is_latch),
            .data_wr   (bus_wr && (bus_addr == ADDR_W'(gi))),
            .data_rd   (bus_rd && (bus_addr == ADDR_W'(gi))),
            .wdata     (bus_wdata),
            .rdata     (ch_rdata[gi]),
            .out       (tmr_out[gi]),
            .evt       (ch_evt[gi]),
            .cnt       (ch_cnt[gi]),
            .rld       (ch_rld[gi]),
            .held      (ch_held[gi]),
            .snap      (ch_snap[gi])
        );
    end

    pit_sysctl u_sys (
        .clk     (clk),
        .rst     (rst),
        .wr      (sys_wr),
        .gate_in (bus_wdata[SYS_GATE_BIT]),
        .clr_in  (bus_wdata[SYS_IRQ_BIT]),
        .set_evt (ch_evt[IRQ_CH]),
        .tone    (tmr_out[SPK_CH]),
        .gate_o  (sys_gate),
        .irq_o   (irq_o),
        .rdata   (sys_rdata)
    );

    assign spk_o = tmr_out[SPK_CH] & sys_gate;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_SYS)
            bus_rdata = sys_rdata;
        for (int i = 0; i < NUM_CH; i++)
            if (bus_addr == ADDR_W'(i))
                bus_rdata = ch_rdata[i];
    end

endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int IRQ_CH = 0
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         cnt_tick,
    input logic                         bus_wr,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic                         clr_bit,
    input logic                         irq_o,
    input logic                         spk_o,
    input logic                         tone,
    input logic [NUM_CH-1:0]            ch_evt,
    input logic [NUM_CH-1:0]            ch_held,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_rld,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_snap
);

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_a
        // R12
        cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!cnt_tick && !(bus_wr && bus_addr == ADDR_W'(gi))) |=> $stable(ch_cnt[gi]));
        // R4
        reload_chk: assert property (@(posedge clk) disable iff (rst)
            ch_evt[gi] |=> (ch_cnt[gi] == $past(ch_rld[gi])));
        // R7
        snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
            ch_held[gi] |=> $stable(ch_snap[gi]));
    end

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(ch_evt[IRQ_CH]));

    // R10
    irq_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !(bus_wr && bus_addr == ADDR_SYS && clr_bit)) |=> irq_o);

    // R9
    spk_chk: assert property (@(posedge clk) disable iff (rst)
        spk_o |-> tone);

endmodule

bind pit_timer pit_timer_chk #(.NUM_CH(NUM_CH), .IRQ_CH(IRQ_CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt_tick (cnt_tick),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .clr_bit  (bus_wdata[7]),
    .irq_o    (irq_o),
    .spk_o    (spk_o),
    .tone     (tmr_out[SPK_CH]),
    .ch_evt   (ch_evt),
    .ch_held  (ch_held),
    .ch_cnt   (ch_cnt),
    .ch_rld   (ch_rld),
    .ch_snap  (ch_snap)
);

// File: tb/test_pit_timer.sv
module test_pit_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_o, spk_o;
    logic [2:0] tmr_out;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pit_timer i_pit_timer (
        .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .spk_o(spk_o), .tmr_out(tmr_out)
    );

    // {reload, expected period in ticks}
    localparam int NV = 5;
    localparam logic [32:0] VEC [NV] = '{
        {16'd5,   17'd5},
        {16'd1,   17'd1},
        {16'd2,   17'd2},
        {16'd300, 17'd300},
        {16'd0,   17'd65536}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        cnt_tick = 1'b1;
        repeat (n) @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    task automatic snap_of(input logic [1:0] ch, output logic [15:0] v);
        logic [7:0] lo, hi;
        wr(3'd3, {ch, 6'b0});
        rd({1'b0, ch}, lo);
        rd({1'b0, ch}, hi);
        v = {hi, lo};
    endtask

    task automatic load(input logic [1:0] ch, input logic [7:0] cmd, input logic [15:0] v);
        wr(3'd3, cmd);
        wr({1'b0, ch}, v[7:0]);
        wr({1'b0, ch}, v[15:8]);
    endtask

    task automatic period(output int n);
        @(negedge clk);
        cnt_tick = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq_o && n < 70000);
        cnt_tick = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  b, b2;
        logic [15:0] v;
        int          n;
        int          exp_sq [7];

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", int'(irq_o), 0);
        check("R1 spk", int'(spk_o), 0);
        check("R1 tmr_out", int'(tmr_out), 7);
        rd(3'd4, b);
        check("R1 R11 sysctl read", int'(b), 8'h20);

        // R4 R5 period table, channel 0 rate mode (cmd 0x34)
        for (int k = 0; k < NV; k++) begin
            load(2'd0, 8'h34, VEC[k][32:17]);
            wr(3'd4, 8'h80);
            period(n);
            check("R4 R5 first period", n, int'(VEC[k][16:0]));
            wr(3'd4, 8'h80);
            if (VEC[k][16:0] < 17'd1000) begin
                period(n);
                check("R4 second period", n, int'(VEC[k][16:0]));
                wr(3'd4, 8'h80);
            end
        end

        // R4 output low while count is 1
        load(2'd0, 8'h34, 16'd4);
        ticks(3);
        check("R4 out low at count 1", int'(tmr_out[0]), 0);
        ticks(1);
        check("R4 out high after reload", int'(tmr_out[0]), 1);

        // R10 write-one-to-clear
        check("R10 irq set", int'(irq_o), 1);
        wr(3'd4, 8'h01);
        check("R10 no clear without bit7", int'(irq_o), 1);
        rd(3'd4, b);
        check("R11 sysctl irq bit", int'(b[7]), 1);
        check("R11 sysctl gate bit", int'(b[0]), 1);
        wr(3'd4, 8'h80);
        check("R10 cleared", int'(irq_o), 0);

        // R3 R12 half-written load
        load(2'd0, 8'h34, 16'd10);
        wr(3'd4, 8'h00);
        snap_of(2'd0, v);
        check("R12 no tick no change", int'(v), 10);
        ticks(3);
        wr(3'd0, 8'h02);
        ticks(2);
        snap_of(2'd0, v);
        check("R3 old count runs", int'(v), 5);
        wr(3'd0, 8'h01);
        snap_of(2'd0, v);
        check("R3 new count after high byte", int'(v), 16'h0102);

        // R6 R7 latch snapshot
        load(2'd0, 8'h34, 16'h1234);
        ticks(3);
        wr(3'd3, 8'h00);
        ticks(5);
        wr(3'd3, 8'h00);
        rd(3'd0, b);
        ticks(2);
        rd(3'd0, b2);
        check("R6 R7 snapshot low", int'(b), 8'h31);
        check("R6 R7 snapshot high", int'(b2), 8'h12);
        snap_of(2'd0, v);
        check("R6 counting went on", int'(v), 16'h122A);

        // R2 selection 3 ignored, reprogramming stops channel
        load(2'd0, 8'h34, 16'h0040);
        ticks(5);
        wr(3'd3, 8'hF4);
        ticks(1);
        snap_of(2'd0, v);
        check("R2 select 3 no effect", int'(v), 16'h003A);
        wr(3'd3, 8'h34);
        ticks(4);
        snap_of(2'd0, v);
        check("R2 stopped after mode write", int'(v), 16'h003A);
        check("R2 idle output", int'(tmr_out[0]), 1);

        // R8 R9 square wave on channel 2 (cmd 0xB6), even reload
        wr(3'd4, 8'h01);
        load(2'd2, 8'hB6, 16'd6);
        check("R8 start high", int'(tmr_out[2]), 1);
        check("R9 spk gated on", int'(spk_o), 1);
        exp_sq = '{1, 1, 0, 0, 0, 1, 1};
        for (int k = 0; k < 7; k++) begin
            ticks(1);
            check("R8 even square", int'(tmr_out[2]), exp_sq[k]);
            if (k == 2) check("R9 spk low with tone", int'(spk_o), 0);
        end
        rd(3'd4, b);
        check("R11 tone bit", int'(b[5]), 1);
        wr(3'd4, 8'h00);
        check("R9 gate off", int'(spk_o), 0);

        // R8 odd reload
        load(2'd2, 8'hB6, 16'd5);
        exp_sq = '{1, 1, 0, 0, 1, 1, 1};
        for (int k = 0; k < 5; k++) begin
            ticks(1);
            check("R8 odd square", int'(tmr_out[2]), exp_sq[k]);
        end

        // R2 channel independence: ch0 held still
        snap_of(2'd0, v);
        check("R2 ch0 untouched by ch2", int'(v), 16'h003A);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule